// File: doc/BRIEF.md
# Burst-Fill Single-Line Read Cache

This block serves 32-bit word reads for a simple client from a single buffered memory line. If the client asks for a word whose line is not held, the block starts one burst read of a full 16-word, 64-byte line on a memory-mapped bus master port. That port has a read strobe, a waitrequest back-pressure input and a per-beat readdatavalid qualifier. As the beats arrive the block stores them in a local line buffer. When the line is complete, the block returns the requested word, and later requests to the same line are answered from the buffer with no bus traffic.

The client presents `cl_req` with a byte address while `cl_ready` is high. On the cycle after acceptance, if `cl_ready` is still high, the request was a hit and `cl_data` holds the word. If `cl_ready` is low, a fill is running, and `cl_data` holds the word on the first cycle `cl_ready` returns high. Beats that arrive while no fill is pending are dropped and raise a sticky error flag. The memory side is known to fail without any sign on short bursts, so the burst length is never below 8.

Top module: `line_fill_cache`

## Requirements
- R1: After reset `cl_ready` is 1, `bus_read` is 0, `stray_err` is 0, and the buffered line is invalid, so the first client request is always a miss.
- R2: A miss drives exactly one read request whose `bus_addr` is the client byte address with bits [5:0] cleared, with `bus_burstcount` equal to 16 (never below 8). It is seen as one rising edge of `bus_read` and one accepted cycle (`bus_read` high, `bus_waitrequest` low) per fill.
- R3: `bus_read` stays high on each cycle after a cycle where it was high with `bus_waitrequest` high, and it is low on the cycle after the request is accepted.
- R4: `bus_addr` and `bus_burstcount` do not change while a read request waits on `bus_waitrequest`.
- R5: Beats are taken only on cycles with `bus_readdatavalid` high and are written to buffer words 0 to 15 in arrival order, whatever the gaps between beats. Word k of the line is the one at byte offset 4*k.
- R6: `cl_ready` is low from the cycle after a miss is accepted until the sixteenth beat is taken. On the cycle after that beat it is high and `cl_data` holds the requested word, selected by address bits [5:2].
- R7: A request whose address bits [31:6] match the valid buffered line returns that word on `cl_data` on the next cycle, with `cl_ready` high and no bus read.
- R8: `bus_readdatavalid` while no fill is pending leaves the buffer unchanged and sets `stray_err`, which then stays 1 until reset.
- R9: A `cl_req` while `cl_ready` is low is ignored: it starts no bus read and does not change the word returned for the pending request.
- R10: A miss to a new line replaces the buffered line, so a later request to the earlier line misses again and starts a new fill.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cl_req | input | 1 | Client read request, taken when `cl_ready` is high |
| cl_addr | input | 32 | Client byte address |
| cl_ready | output | 1 | High when idle and able to take a request |
| cl_data | output | 32 | Returned word |
| bus_addr | output | 32 | Line-aligned burst start address |
| bus_read | output | 1 | Read request strobe |
| bus_burstcount | output | 5 | Burst length in beats |
| bus_waitrequest | input | 1 | Bus stall for the request strobe |
| bus_readdata | input | 32 | Returned beat data |
| bus_readdatavalid | input | 1 | Qualifies `bus_readdata` |
| stray_err | output | 1 | Sticky flag for beats that arrived with no fill pending |

## Verification
The assertions assume the bus obeys the usual read handshake: waitrequest only stalls a request that is being driven, and each accepted burst returns exactly the number of beats it asked for, with nothing extra except where a stray beat is injected on purpose. The bench's bus model returns exactly sixteen beats per accepted request and injects a stray beat only while the block is idle. It presents client requests only on cycles where the model of `cl_ready` says they will be taken, apart from the one scenario that deliberately requests during a fill. It varies waitrequest stalls and gaps between beats so that the in-order placement of beats is exercised against an address-derived memory pattern.

// File: rtl/line_cache_pkg.sv
package line_cache_pkg;
   typedef enum logic [1:0] {
      FS_IDLE  = 2'd0,
      FS_REQ   = 2'd1,
      FS_BEATS = 2'd2
   } fill_state_t;
endpackage

// File: rtl/lc_fill_ctrl.sv
module lc_fill_ctrl
   import line_cache_pkg::*;
#(
   parameter int LINE_WORDS = 16,
   localparam int IDX_W = $clog2(LINE_WORDS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             waitreq,
   input  logic             rdvalid,
   output fill_state_t      state,
   output logic [IDX_W-1:0] beat_idx,
   output logic             beat_we,
   output logic             fill_done,
   output logic             stray
);
   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(LINE_WORDS - 1);

   fill_state_t      state_q;
   logic [IDX_W-1:0] cnt_q;

   assign state     = state_q;
   assign beat_idx  = cnt_q;
   assign beat_we   = (state_q == FS_BEATS) && rdvalid;
   assign fill_done = beat_we && (cnt_q == LAST_IDX);
   assign stray     = rdvalid && (state_q != FS_BEATS);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= FS_IDLE;
         cnt_q   <= '0;
      end else begin
         unique case (state_q)
            FS_IDLE: begin
               if (start) begin
                  state_q <= FS_REQ;
                  cnt_q   <= '0;
               end
            end
            FS_REQ: begin
               if (!waitreq) state_q <= FS_BEATS;
            end
            FS_BEATS: begin
               if (rdvalid) begin
                  cnt_q <= cnt_q + 1'b1;
                  if (cnt_q == LAST_IDX) state_q <= FS_IDLE;
               end
            end
            default: state_q <= FS_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/lc_line_store.sv
module lc_line_store #(
   parameter int WORD_W     = 32,
   parameter int LINE_WORDS = 16,
   localparam int IDX_W = $clog2(LINE_WORDS)
) (
   input  logic              clk,
   input  logic              we,
   input  logic [IDX_W-1:0]  widx,
   input  logic [WORD_W-1:0] wdata,
   input  logic [IDX_W-1:0]  ridx,
   output logic [WORD_W-1:0] rdata
);
   logic [WORD_W-1:0] words [LINE_WORDS];

   for (genvar g = 0; g < LINE_WORDS; g++) begin : g_word
      logic [WORD_W-1:0] q;
      always_ff @(posedge clk) begin
         if (we && (widx == IDX_W'(g))) q <= wdata;
      end
      assign words[g] = q;
   end

   assign rdata = words[ridx];
endmodule

// File: rtl/lc_tag_unit.sv
module lc_tag_unit #(
   parameter int TAG_W = 26
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             invalidate,
   input  logic             load,
   input  logic [TAG_W-1:0] load_tag,
   input  logic [TAG_W-1:0] look_tag,
   output logic             hit
);
   logic             valid_q;
   logic [TAG_W-1:0] tag_q;

   assign hit = valid_q && (tag_q == look_tag);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid_q <= 1'b0;
         tag_q   <= '0;
      end else if (load) begin
         valid_q <= 1'b1;
         tag_q   <= load_tag;
      end else if (invalidate) begin
         valid_q <= 1'b0;
      end
   end
endmodule

// File: rtl/line_fill_cache.sv
module line_fill_cache
   import line_cache_pkg::*;
#(
   parameter int ADDR_W     = 32,
   parameter int WORD_W     = 32,
   parameter int LINE_WORDS = 16,
   parameter int MIN_BURST  = 8,
   localparam int IDX_W  = $clog2(LINE_WORDS),
   localparam int BYTE_W = $clog2(WORD_W / 8),
   localparam int OFF_W  = IDX_W + BYTE_W,
   localparam int TAG_W  = ADDR_W - OFF_W,
   localparam int BC_W   = $clog2(LINE_WORDS) + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cl_req,
   input  logic [ADDR_W-1:0] cl_addr,
   output logic              cl_ready,
   output logic [WORD_W-1:0] cl_data,
   output logic [ADDR_W-1:0] bus_addr,
   output logic              bus_read,
   output logic [BC_W-1:0]   bus_burstcount,
   input  logic              bus_waitrequest,
   input  logic [WORD_W-1:0] bus_readdata,
   input  logic              bus_readdatavalid,
   output logic              stray_err
);
   if (LINE_WORDS < MIN_BURST) begin : g_bad_burst
      $error("line length below the minimum burst");
   end
   if (MIN_BURST < 8) begin : g_bad_min
      $error("minimum burst must be at least 8 beats");
   end
   if ((1 << IDX_W) != LINE_WORDS) begin : g_bad_pow2
      $error("line length must be a power of two");
   end
   if ((WORD_W % 8) != 0 || (1 << BYTE_W) * 8 != WORD_W) begin : g_bad_word
      $error("word width must be a power-of-two number of bytes");
   end

   fill_state_t      state;
   logic [IDX_W-1:0] beat_idx;
   logic             beat_we, fill_done, stray, hit;
   logic [WORD_W-1:0] store_rd;

   logic [TAG_W-1:0] base_tag_q;
   logic [IDX_W-1:0] pend_idx_q;
   logic [WORD_W-1:0] data_q;
   logic             err_q;

   logic [TAG_W-1:0] req_tag;
   logic [IDX_W-1:0] req_idx;
   logic             accept, miss_start;

   assign req_tag    = cl_addr[ADDR_W-1:OFF_W];
   assign req_idx    = cl_addr[OFF_W-1:BYTE_W];
   assign cl_ready   = (state == FS_IDLE);
   assign accept     = cl_req && cl_ready;
   assign miss_start = accept && !hit;

   lc_fill_ctrl #(.LINE_WORDS(LINE_WORDS)) u_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (miss_start),
      .waitreq  (bus_waitrequest),
      .rdvalid  (bus_readdatavalid),
      .state    (state),
      .beat_idx (beat_idx),
      .beat_we  (beat_we),
      .fill_done(fill_done),
      .stray    (stray)
   );

   lc_line_store #(.WORD_W(WORD_W), .LINE_WORDS(LINE_WORDS)) u_store (
      .clk  (clk),
      .we   (beat_we),
      .widx (beat_idx),
      .wdata(bus_readdata),
      .ridx (req_idx),
      .rdata(store_rd)
   );

   lc_tag_unit #(.TAG_W(TAG_W)) u_tag (
      .clk       (clk),
      .rst_n     (rst_n),
      .invalidate(miss_start),
      .load      (fill_done),
      .load_tag  (base_tag_q),
      .look_tag  (req_tag),
      .hit       (hit)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         base_tag_q <= '0;
         pend_idx_q <= '0;
         data_q     <= '0;
         err_q      <= 1'b0;
      end else begin
         if (stray) err_q <= 1'b1;
         if (accept) begin
            pend_idx_q <= req_idx;
            if (hit) data_q     <= store_rd;
            else     base_tag_q <= req_tag;
         end
         if (beat_we && (beat_idx == pend_idx_q)) data_q <= bus_readdata;
      end
   end

   assign cl_data        = data_q;
   assign stray_err      = err_q;
   assign bus_read       = (state == FS_REQ);
   assign bus_addr       = {base_tag_q, {OFF_W{1'b0}}};
   assign bus_burstcount = BC_W'(LINE_WORDS);
endmodule

// File: rtl/line_fill_cache_chk.sv
module line_fill_cache_chk #(
   parameter int ADDR_W = 32,
   parameter int OFF_W  = 6,
   parameter int BC_W   = 5
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cl_ready,
   input logic [ADDR_W-1:0] bus_addr,
   input logic              bus_read,
   input logic [BC_W-1:0]   bus_burstcount,
   input logic              bus_waitrequest,
   input logic              stray_err
);
   assert_read_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_read && bus_waitrequest) |=> bus_read);

   assert_one_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_read && !bus_waitrequest) |=> !bus_read);

   assert_req_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_read && bus_waitrequest) |=> ($stable(bus_addr) && $stable(bus_burstcount)));

   assert_line_aligned_R2: assert property (@(posedge clk) disable iff (!rst_n)
      bus_read |-> (bus_addr[OFF_W-1:0] == '0));

   assert_busy_during_fill_R6: assert property (@(posedge clk) disable iff (!rst_n)
      bus_read |-> !cl_ready);

   assert_err_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
      stray_err |=> stray_err);
endmodule

bind line_fill_cache line_fill_cache_chk #(
   .ADDR_W(ADDR_W),
   .OFF_W (OFF_W),
   .BC_W  (BC_W)
) u_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .cl_ready       (cl_ready),
   .bus_addr       (bus_addr),
   .bus_read       (bus_read),
   .bus_burstcount (bus_burstcount),
   .bus_waitrequest(bus_waitrequest),
   .stray_err      (stray_err)
);

// File: tb/line_fill_cache_bench.sv
module line_fill_cache_bench;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cl_req = 1'b0;
   logic [31:0] cl_addr = '0;
   logic        cl_ready;
   logic [31:0] cl_data;
   logic [31:0] bus_addr;
   logic        bus_read;
   logic [4:0]  bus_burstcount;
   logic        bus_waitrequest = 1'b0;
   logic [31:0] bus_readdata = '0;
   logic        bus_readdatavalid = 1'b0;
   logic        stray_err;

   int total = 0;
   int bad = 0;
   int n_acc = 0;
   int n_rise = 0;
   logic read_d = 1'b0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   line_fill_cache u_line_fill_cache (
      .clk              (clk),
      .rst_n            (rst_n),
      .cl_req           (cl_req),
      .cl_addr          (cl_addr),
      .cl_ready         (cl_ready),
      .cl_data          (cl_data),
      .bus_addr         (bus_addr),
      .bus_read         (bus_read),
      .bus_burstcount   (bus_burstcount),
      .bus_waitrequest  (bus_waitrequest),
      .bus_readdata     (bus_readdata),
      .bus_readdatavalid(bus_readdatavalid),
      .stray_err        (stray_err)
   );

   always @(posedge clk) begin
      if (bus_read && !bus_waitrequest) n_acc++;
      if (bus_read && !read_d) n_rise++;
      read_d <= bus_read;
   end

   function automatic logic [31:0] memw(input logic [31:0] a);
      return {a[15:0], ~a[15:0]} ^ 32'h1357_9bdf;
   endfunction

   task automatic chk(input bit ok, input string req, input logic [31:0] act,
                      input logic [31:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // miss: waits w cycles on waitrequest, gap mode adds idle cycles between beats
   task automatic do_miss(input logic [31:0] a, input int w, input int gapmod,
                          input bit poke_during);
      logic [31:0] base;
      int acc0, rise0;
      base  = {a[31:6], 6'd0};
      acc0  = n_acc;
      rise0 = n_rise;
      @(negedge clk);
      cl_req = 1'b1; cl_addr = a; bus_waitrequest = (w > 0);
      @(negedge clk);
      cl_req = 1'b0;
      chk(cl_ready == 1'b0, "R6 ready low after miss", 32'(cl_ready), 32'd0);
      chk(bus_read == 1'b1, "R2 read issued", 32'(bus_read), 32'd1);
      chk(bus_addr == base, "R2 line address", bus_addr, base);
      chk(bus_burstcount == 5'd16, "R2 burstcount", 32'(bus_burstcount), 32'd16);
      if (w == 0) begin
         @(negedge clk);
         chk(bus_read == 1'b0, "R3 read drops after accept", 32'(bus_read), 32'd0);
      end else begin
         for (int i = 0; i < w; i++) begin
            if (i == w - 1) bus_waitrequest = 1'b0;
            @(negedge clk);
            chk(bus_read == (i < w - 1), "R3 read held under waitrequest",
                32'(bus_read), 32'(i < w - 1));
            if (i < w - 1)
               chk(bus_addr == base, "R4 address stable", bus_addr, base);
         end
      end
      for (int b = 0; b < 16; b++) begin
         bus_readdatavalid = 1'b1;
         bus_readdata = memw(base + 32'(4 * b));
         if (poke_during && b == 5) begin
            cl_req = 1'b1; cl_addr = 32'h4000_0000;
         end
         @(negedge clk);
         cl_req = 1'b0;
         bus_readdatavalid = 1'b0;
         bus_readdata = 32'hdead_beef;
         if (b < 15)
            chk(cl_ready == 1'b0, "R6 ready low during fill", 32'(cl_ready), 32'd0);
         for (int g = 0; g < (gapmod == 0 ? 0 : (b % gapmod)); g++) @(negedge clk);
      end
      chk(cl_ready == 1'b1, "R6 ready after last beat", 32'(cl_ready), 32'd1);
      chk(cl_data == memw({a[31:2], 2'd0}), "R6 requested word", cl_data,
          memw({a[31:2], 2'd0}));
      chk(n_acc == acc0 + 1, poke_during ? "R9 one fill despite request" : "R2 one accept",
          32'(n_acc), 32'(acc0 + 1));
      chk(n_rise == rise0 + 1, "R2 single read pulse", 32'(n_rise), 32'(rise0 + 1));
   endtask

   task automatic do_hit(input logic [31:0] a);
      int acc0;
      acc0 = n_acc;
      @(negedge clk);
      cl_req = 1'b1; cl_addr = a;
      @(negedge clk);
      cl_req = 1'b0;
      chk(cl_ready == 1'b1, "R7 ready on hit", 32'(cl_ready), 32'd1);
      chk(bus_read == 1'b0, "R7 no bus read on hit", 32'(bus_read), 32'd0);
      chk(cl_data == memw({a[31:2], 2'd0}), "R7/R5 hit data", cl_data,
          memw({a[31:2], 2'd0}));
      @(negedge clk);
      chk(n_acc == acc0, "R7 no bus accept on hit", 32'(n_acc), 32'(acc0));
   endtask

   task automatic t_reset();
      chk(cl_ready == 1'b1, "R1 ready after reset", 32'(cl_ready), 32'd1);
      chk(bus_read == 1'b0, "R1 read low after reset", 32'(bus_read), 32'd0);
      chk(stray_err == 1'b0, "R1 error clear after reset", 32'(stray_err), 32'd0);
   endtask

   task automatic t_first_line();
      // R1: first request misses even though nothing was loaded
      do_miss(32'h1000_0048, 0, 0, 1'b0);
      for (int k = 0; k < 16; k++) do_hit(32'h1000_0040 + 32'(4 * k));
   endtask

   task automatic t_gappy_line();
      // R5: stalls and uneven gaps between beats
      do_miss(32'h2000_00fe, 3, 3, 1'b0);
      do_hit(32'h2000_00c0);
      do_hit(32'h2000_00e4);
      do_hit(32'h2000_00f8);
   endtask

   task automatic t_req_during_fill();
      // R9 then R10
      do_miss(32'h3000_0004, 1, 2, 1'b1);
      do_hit(32'h3000_003c);
      do_miss(32'h2000_00c8, 2, 0, 1'b0);
   endtask

   task automatic t_stray();
      chk(stray_err == 1'b0, "R8 error clear before stray", 32'(stray_err), 32'd0);
      @(negedge clk);
      bus_readdatavalid = 1'b1; bus_readdata = 32'h0bad_0bad;
      @(negedge clk);
      bus_readdatavalid = 1'b0;
      @(negedge clk);
      chk(stray_err == 1'b1, "R8 error set on stray beat", 32'(stray_err), 32'd1);
      do_hit(32'h2000_00c0);
      do_hit(32'h2000_00c8);
      repeat (5) @(negedge clk);
      chk(stray_err == 1'b1, "R8 error sticky", 32'(stray_err), 32'd1);
   endtask

   bit done = 1'b0;

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_first_line();
      t_gappy_line();
      t_req_during_fill();
      t_stray();
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 150000);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule